// File: doc/BRIEF.md
# Two-Port Transmit Arbiter with Collision Generation

This block joins two attachment-unit transmit streams onto one network transmit path. Each DTE port presents an activity flag and a data bit. The block qualifies every activity flag against short glitches and short idle gaps, picks the stream that drives the network output, and repeats the accepted data to both DTE receive paths. When no DTE is sending, data from the network receive input is repeated to both DTE receive paths instead.

The block flags a collision when both DTE ports are sending at once. It also flags one when the network collision-in flag is qualified active while the inter-packet test window is closed. During a collision, port 1 has priority and takes over the network output in mid-packet. While a collision is present, a gated square wave is produced for both DTE collision pairs. Activity from a port whose jabber block flag is set is treated as absent.

Every time constant counts cycles of one fast system clock. With a 100 MHz clock and the default parameters, one bit time is 10 cycles and the wave has a 10-cycle period.

Top module: `tx_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after release, every output is 0.
- R2: An activity input (either DTE port, network receive, network collision-in) becomes qualified active only after ON_CYC consecutive high samples. A shorter high pulse changes no output.
- R3: A qualified-active input becomes idle only after OFF_CYC consecutive low samples. A shorter low gap changes no output.
- R4: A DTE port whose block flag is high is treated as inactive for arbitration, forwarding and collision detection in that cycle.
- R5: One cycle after the qualified state, the network transmit outputs behave as follows. `net_tx_act_o` is high when either unblocked DTE port is active. `net_tx_dat_o` carries port 1 data if port 1 is active, otherwise port 2 data, otherwise 0. `tx_owner_o` is 2'b01 when port 1 drives, 2'b10 when port 2 drives and 2'b00 when idle.
- R6: One cycle after the qualified state, the DTE receive outputs follow a priority order. When a DTE port is active they carry the selected transmit data. Otherwise, when network receive is active, they carry `net_rx_dat_i`. Otherwise they are 0. `dte_rx_act_o` is high in either of the two active cases.
- R7: A collision condition exists when both unblocked DTE ports are active, or when network collision-in is active while `sqe_win_i` is low.
- R8: `col_present_o` rises one cycle after the collision condition appears. It falls exactly HOLD_BITS*BIT_CYC+1 cycles after the condition clears, and a fresh condition during the hold restarts the hold.
- R9: `col_wave_o` is high in the first cycle of `col_present_o` and then toggles every HALF_CYC cycles. It is 0 whenever `col_present_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dte1_act_i | input | 1 | Port 1 transmit activity (squelched) |
| dte1_dat_i | input | 1 | Port 1 transmit data |
| dte2_act_i | input | 1 | Port 2 transmit activity (squelched) |
| dte2_dat_i | input | 1 | Port 2 transmit data |
| net_rx_act_i | input | 1 | Network receive activity |
| net_rx_dat_i | input | 1 | Network receive data |
| net_col_act_i | input | 1 | Network collision-in activity |
| sqe_win_i | input | 1 | High during the inter-packet SQE test window |
| dte1_block_i | input | 1 | Jabber disable for port 1 |
| dte2_block_i | input | 1 | Jabber disable for port 2 |
| net_tx_act_o | output | 1 | Network transmit active |
| net_tx_dat_o | output | 1 | Network transmit data |
| tx_owner_o | output | 2 | Port driving the network output (one-hot) |
| dte_rx_act_o | output | 1 | DTE receive paths active |
| dte_rx_dat_o | output | 1 | Data repeated to both DTE receive paths |
| col_present_o | output | 1 | Collision indication including hold-off |
| col_wave_o | output | 1 | Gated collision square wave for both DTE ports |

## Verification
The bench builds the block with BIT_CYC=4, HALF_CYC=2, ON_CYC=2, OFF_CYC=3 and HOLD_BITS=2, so the hold-off is 8 cycles and a full wave period is 4 cycles. At these sizes, segments of only 1 to 20 cycles cross every threshold. Pulses shorter than, equal to and longer than the qualify and idle limits all occur, and a collision can re-arm inside its own hold-off. All 64 combinations of the six activity, window and block flags are swept through many pairwise transitions. Each output is compared every cycle against an arithmetic model of the requirements.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_P1   = 2'b01,
        OWN_P2   = 2'b10
    } owner_e;

    // indices into the qualified activity vector
    localparam int IDX_P1  = 0;
    localparam int IDX_P2  = 1;
    localparam int IDX_RX  = 2;
    localparam int IDX_COL = 3;
    localparam int N_QUAL  = 4;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/act_qualifier.sv
module act_qualifier #(
    parameter int ON_CYC  = 2,
    parameter int OFF_CYC = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic act_o
);
    localparam int RUN_W = $clog2(arb_pkg::max2(ON_CYC, OFF_CYC) + 1);
    localparam logic [RUN_W:0] ON_L  = (RUN_W + 1)'(ON_CYC);
    localparam logic [RUN_W:0] OFF_L = (RUN_W + 1)'(OFF_CYC);

    typedef struct packed {
        logic             act;
        logic [RUN_W-1:0] run;
    } qual_t;

    qual_t s_d, s_q;
    logic [RUN_W:0] run_inc;

    always_comb begin
        s_d     = s_q;
        run_inc = {1'b0, s_q.run} + 1'b1;
        // the run counter counts consecutive samples that disagree with act
        if (raw_i != s_q.act) begin
            if (run_inc >= (s_q.act ? OFF_L : ON_L)) begin
                s_d.act = raw_i;
                s_d.run = '0;
            end else begin
                s_d.run = run_inc[RUN_W-1:0];
            end
        end else begin
            s_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_o = s_q.act;
endmodule

// File: rtl/col_gen.sv
module col_gen #(
    parameter int HOLD_CYC = 30,
    parameter int HALF_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic present_o,
    output logic wave_o
);
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int PW = $clog2(HALF_CYC + 1);
    localparam logic [HW-1:0] HOLD_L  = HW'(HOLD_CYC);
    localparam logic [PW-1:0] PH_LAST = PW'(HALF_CYC - 1);

    typedef struct packed {
        logic          present;
        logic          wave;
        logic [HW-1:0] hold;
        logic [PW-1:0] phase;
    } col_t;

    col_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // presence with hold-off after the condition clears
        if (cond_i) begin
            s_d.present = 1'b1;
            s_d.hold    = HOLD_L;
        end else if (s_q.present) begin
            if (s_q.hold == '0) s_d.present = 1'b0;
            else                s_d.hold    = s_q.hold - 1'b1;
        end
        // square wave gated by presence
        if (!s_d.present) begin
            s_d.wave  = 1'b0;
            s_d.phase = '0;
        end else if (!s_q.present) begin
            s_d.wave  = 1'b1;
            s_d.phase = '0;
        end else if (s_q.phase == PH_LAST) begin
            s_d.wave  = ~s_q.wave;
            s_d.phase = '0;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign present_o = s_q.present;
    assign wave_o    = s_q.wave;
endmodule

// File: rtl/tx_arbiter.sv
module tx_arbiter #(
    parameter int BIT_CYC   = 10,
    parameter int HALF_CYC  = 5,
    parameter int ON_CYC    = 2,
    parameter int OFF_CYC   = 19,
    parameter int HOLD_BITS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dte1_act_i,
    input  logic       dte1_dat_i,
    input  logic       dte2_act_i,
    input  logic       dte2_dat_i,
    input  logic       net_rx_act_i,
    input  logic       net_rx_dat_i,
    input  logic       net_col_act_i,
    input  logic       sqe_win_i,
    input  logic       dte1_block_i,
    input  logic       dte2_block_i,
    output logic       net_tx_act_o,
    output logic       net_tx_dat_o,
    output logic [1:0] tx_owner_o,
    output logic       dte_rx_act_o,
    output logic       dte_rx_dat_o,
    output logic       col_present_o,
    output logic       col_wave_o
);
    import arb_pkg::*;

    localparam int HOLD_CYC = HOLD_BITS * BIT_CYC;

    typedef struct packed {
        logic   tx_act;
        logic   tx_dat;
        owner_e owner;
        logic   rx_act;
        logic   rx_dat;
    } out_t;

    logic [N_QUAL-1:0] raw, qact;
    logic p1, p2, col_cond;
    out_t o_d, o_q;

    assign raw[IDX_P1]  = dte1_act_i;
    assign raw[IDX_P2]  = dte2_act_i;
    assign raw[IDX_RX]  = net_rx_act_i;
    assign raw[IDX_COL] = net_col_act_i;

    for (genvar g = 0; g < N_QUAL; g++) begin : g_qual
        act_qualifier #(
            .ON_CYC (ON_CYC),
            .OFF_CYC(OFF_CYC)
        ) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .raw_i(raw[g]),
            .act_o(qact[g])
        );
    end

    always_comb begin
        p1       = qact[IDX_P1] & ~dte1_block_i;
        p2       = qact[IDX_P2] & ~dte2_block_i;
        col_cond = (p1 & p2) | (qact[IDX_COL] & ~sqe_win_i);

        o_d = '0;
        if (p1) begin
            o_d.owner  = OWN_P1;
            o_d.tx_dat = dte1_dat_i;
        end else if (p2) begin
            o_d.owner  = OWN_P2;
            o_d.tx_dat = dte2_dat_i;
        end else begin
            o_d.owner  = OWN_NONE;
        end
        o_d.tx_act = p1 | p2;
        if (o_d.tx_act) begin
            o_d.rx_act = 1'b1;
            o_d.rx_dat = o_d.tx_dat;
        end else if (qact[IDX_RX]) begin
            o_d.rx_act = 1'b1;
            o_d.rx_dat = net_rx_dat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    col_gen #(
        .HOLD_CYC(HOLD_CYC),
        .HALF_CYC(HALF_CYC)
    ) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_i   (col_cond),
        .present_o(col_present_o),
        .wave_o   (col_wave_o)
    );

    assign net_tx_act_o = o_q.tx_act;
    assign net_tx_dat_o = o_q.tx_dat;
    assign tx_owner_o   = o_q.owner;
    assign dte_rx_act_o = o_q.rx_act;
    assign dte_rx_dat_o = o_q.rx_dat;
endmodule

// File: rtl/arb_chk.sv
module arb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] qact,
    input logic       dte1_act_i,
    input logic       dte1_block_i,
    input logic       dte2_block_i,
    input logic       net_tx_act_o,
    input logic [1:0] tx_owner_o,
    input logic       col_present_o,
    input logic       col_wave_o
);
    AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_owner_o)); // R5
    AST_ACT_MATCHES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        net_tx_act_o == (tx_owner_o != 2'b00)); // R5
    AST_P1_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (qact[0] && !dte1_block_i) |=> tx_owner_o == 2'b01); // R5
    AST_BLOCKED_P1: assert property (@(posedge clk) disable iff (!rst_n)
        dte1_block_i |=> !tx_owner_o[0]); // R4
    AST_QUAL_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qact[0]) |-> $past(dte1_act_i)); // R2
    AST_BOTH_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (qact[0] && qact[1] && !dte1_block_i && !dte2_block_i) |=> col_present_o); // R7
    AST_WAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !col_present_o |-> !col_wave_o); // R9
    AST_WAVE_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_present_o) |-> col_wave_o); // R9
endmodule

bind tx_arbiter arb_chk u_arb_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .qact         (qact),
    .dte1_act_i   (dte1_act_i),
    .dte1_block_i (dte1_block_i),
    .dte2_block_i (dte2_block_i),
    .net_tx_act_o (net_tx_act_o),
    .tx_owner_o   (tx_owner_o),
    .col_present_o(col_present_o),
    .col_wave_o   (col_wave_o)
);

// File: tb/tx_arbiter_bench.sv
`timescale 1ns/1ps
module tx_arbiter_bench;
    localparam int BIT_CYC = 4, HALF_CYC = 2, ON_CYC = 2, OFF_CYC = 3, HOLD_BITS = 2;
    localparam int HOLD = HOLD_BITS * BIT_CYC;

    logic clk = 1'b0, rst_n = 1'b0;
    logic a1 = 0, d1 = 0, a2 = 0, d2 = 0, ra = 0, rd = 0, ca = 0, sw = 0, b1 = 0, b2 = 0;
    logic tx_act, tx_dat, rx_act, rx_dat, col_p, col_w;
    logic [1:0] owner;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tx_arbiter #(.BIT_CYC(BIT_CYC), .HALF_CYC(HALF_CYC), .ON_CYC(ON_CYC),
                 .OFF_CYC(OFF_CYC), .HOLD_BITS(HOLD_BITS)) u_tx_arbiter (
        .clk(clk), .rst_n(rst_n),
        .dte1_act_i(a1), .dte1_dat_i(d1), .dte2_act_i(a2), .dte2_dat_i(d2),
        .net_rx_act_i(ra), .net_rx_dat_i(rd), .net_col_act_i(ca), .sqe_win_i(sw),
        .dte1_block_i(b1), .dte2_block_i(b2),
        .net_tx_act_o(tx_act), .net_tx_dat_o(tx_dat), .tx_owner_o(owner),
        .dte_rx_act_o(rx_act), .dte_rx_dat_o(rx_dat),
        .col_present_o(col_p), .col_wave_o(col_w));

    // arithmetic model of the requirements
    bit q[4];
    int run[4];
    bit e_tx_act, e_tx_dat, e_rx_act, e_rx_dat, e_col, e_wave;
    bit [1:0] e_owner;
    int hold, ph;

    always @(posedge clk) begin
        bit raw[4];
        bit p1, p2, cond, ncol;
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin q[k] = 0; run[k] = 0; end
            e_tx_act = 0; e_tx_dat = 0; e_rx_act = 0; e_rx_dat = 0;
            e_owner = 0; e_col = 0; e_wave = 0; hold = 0; ph = 0;
        end else begin
            raw[0] = a1; raw[1] = a2; raw[2] = ra; raw[3] = ca;
            p1 = q[0] && !b1;                      // R4
            p2 = q[1] && !b2;
            cond = (p1 && p2) || (q[3] && !sw);    // R7
            e_owner  = p1 ? 2'b01 : (p2 ? 2'b10 : 2'b00);   // R5
            e_tx_act = p1 || p2;
            e_tx_dat = p1 ? d1 : (p2 ? d2 : 1'b0);
            e_rx_act = e_tx_act || q[2];           // R6
            e_rx_dat = e_tx_act ? e_tx_dat : (q[2] ? rd : 1'b0);
            ncol = e_col;                          // R8
            if (cond) begin ncol = 1; hold = HOLD; end
            else if (e_col) begin
                if (hold == 0) ncol = 0; else hold = hold - 1;
            end
            if (!ncol) begin e_wave = 0; ph = 0; end          // R9
            else if (!e_col) begin e_wave = 1; ph = 0; end
            else if (ph == HALF_CYC - 1) begin e_wave = !e_wave; ph = 0; end
            else ph = ph + 1;
            e_col = ncol;
            for (int k = 0; k < 4; k++) begin       // R2 R3
                if (raw[k] != q[k]) begin
                    run[k] = run[k] + 1;
                    if (run[k] >= (q[k] ? OFF_CYC : ON_CYC)) begin q[k] = raw[k]; run[k] = 0; end
                end else run[k] = 0;
            end
        end
    end

    task automatic chk(input string req, input string sig, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at cycle %0d", req, sig, got, exp, cyc);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R5"}, "net_tx_act", tx_act, e_tx_act);
        chk({tag, " R5"}, "net_tx_dat", tx_dat, e_tx_dat);
        chk({tag, " R5"}, "tx_owner", owner, e_owner);
        chk({tag, " R6"}, "dte_rx_act", rx_act, e_rx_act);
        chk({tag, " R6"}, "dte_rx_dat", rx_dat, e_rx_dat);
        chk({tag, " R8"}, "col_present", col_p, e_col);
        chk({tag, " R9"}, "col_wave", col_w, e_wave);
    endtask

    // one cycle: drive after the falling edge, compare before the next one
    task automatic step(input bit [5:0] f, input string tag);
        @(negedge clk);
        compare_all(tag);
        cyc++;
        {b2, b1, sw, ca, a2, a1} = f[5:0];
        ra = f[0] ^ f[3];
        d1 = cyc[0] ^ cyc[3];
        d2 = cyc[1];
        rd = cyc[2] ^ cyc[0];
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lens[7] = '{1, 2, 3, 5, 8, 14, 20};
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", "reset outputs", {tx_act, tx_dat, owner, rx_act, rx_dat, col_p, col_w}, 0);
        @(negedge clk) rst_n = 1'b1;
        step(6'd0, "R1 post-reset");
        chk("R1", "first cycle outputs", {tx_act, tx_dat, owner, rx_act, rx_dat, col_p, col_w}, 0);

        // R2 R3: isolated pulses and gaps of every width around the limits
        for (int w = 1; w <= 5; w++) begin
            for (int k = 0; k < w; k++) step(6'b000001, "R2 pulse");
            for (int k = 0; k < 6; k++) step(6'b000000, "R2 after pulse");
        end
        for (int w = 1; w <= 5; w++) begin
            for (int k = 0; k < 6; k++) step(6'b000010, "R3 active");
            for (int k = 0; k < w; k++) step(6'b000000, "R3 gap");
        end

        // R4 R7 R8 R9: every flag combination held long enough to settle
        for (int s = 0; s < 64; s++)
            for (int k = 0; k < 25; k++) step(6'(s), "R7 steady");

        // R2 R3 R5 R8: pairwise transitions with varied segment lengths
        for (int s = 0; s < 64; s++)
            for (int j = 0; j < 8; j++) begin
                int len = lens[(s + j) % 7];
                for (int k = 0; k < len; k++) step(6'((s * 7 + j * 13) % 64), "R8 sweep");
                for (int k = 0; k < lens[(s + 3 * j) % 7]; k++) step(6'(s), "R5 sweep");
            end

        // R5: port 2 sending, port 1 joins and leaves mid-packet
        for (int k = 0; k < 10; k++) step(6'b000010, "R5 p2 alone");
        for (int k = 0; k < 12; k++) step(6'b000011, "R5 p1 takes over");
        for (int k = 0; k < 20; k++) step(6'b000010, "R5 back to p2");
        for (int k = 0; k < 20; k++) step(6'b000000, "R8 tail");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule